// File: doc/BRIEF.md
# Dual-Clock Scan Chain for Path-Delay Testing

This block is a chain of scan flip-flops with a small test sequencer, built to expose extra delay on one selected combinational path. Every cell has the usual data/scan input multiplexer. It also has its own clock multiplexer, which picks either the functional clock or a second clock of the same frequency. The second clock is shifted in phase by the maximum expected delay of the path under test. When the detection-mode select goes high just after a launch edge, the cell clock sees its next rising edge on the shifted clock. The chain therefore captures the path outputs exactly one path delay after launch, without a fast periodic clock. The cells stay on the shifted clock for the rest of the test.

A test is started by a pulse on `start`. The sequencer shifts the first vector in, one bit per cell clock, with the most significant bit first. It then makes one more shift, which launches the second vector. Scan enable drops for a single capture cycle. The sequencer then shifts the response out through `scan_out` and compares each bit with a golden word under a per-bit care mask. A one-cycle `done` pulse reports the end of the test, and the sticky `mismatch` bit flags a suspected Trojan. When no test is running, the cells load functional data on every clock. The block has no streaming traffic, so there is no valid/ready handshake: the vector, golden and mask words are plain inputs that are held steady for the whole test.

Top module: `dcs_chain`

## Requirements
- R1: While `rst_n` is low, `cell_q`, `scan_en`, `done` and `mismatch` are all 0.
- R2: While idle, `scan_en` is 0 and every cell loads `func_d` on each cell clock edge.
- R3: Each cell is clocked by `clk_ph` while `dm_sel` is 1 and by `clk_fn` otherwise. The first cell edge after the launch therefore samples `func_d` exactly at the `clk_ph` rising edge. A path that is slower than the phase offset captures its value from before the launch.
- R4: After `start`, N shift edges load `vec_i` so that `cell_q` equals `vec_i`. The next edge is the launch edge: it shifts once more with `lbit_i` into cell 0, so `cell_q` becomes `{vec_i[N-2:0], lbit_i}`.
- R5: `scan_en` is 1 during shift-in, launch and shift-out. It is 0 for exactly one cell clock between the launch edge and the capture edge.
- R6: After capture, N shift edges move the response out. Before the k-th of these edges, `scan_out` (the value of cell N-1) shows response bit N-k.
- R7: `mismatch` is the OR over all bits of (response XOR `gold_i`) AND `care_i`.
- R8: `done` is high for exactly one cell clock, beginning at the (N+1)-th cell edge after the launch edge. `mismatch` holds its value until the next accepted `start`, which clears it.
- R9: Bits of `care_i` that are 0 have no effect on `mismatch`.
- R10: A `start` that arrives while a test is running is ignored; the running sequence keeps its timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fn | input | 1 | Functional clock |
| clk_ph | input | 1 | Same-frequency clock, phase shifted by the path delay under test |
| rst_n | input | 1 | Asynchronous active-low reset |
| dm_sel | input | 1 | Detection-mode select; 1 makes every cell use `clk_ph` |
| start | input | 1 | Starts a test when the sequencer is idle |
| vec_i | input | N | First test vector; bit i lands in cell i |
| lbit_i | input | 1 | Bit shifted into cell 0 on the launch edge |
| gold_i | input | N | Known-good response |
| care_i | input | N | Per-bit compare enable |
| func_d | input | N | Functional data: the outputs of the paths under test |
| cell_q | output | N | Cell outputs that drive the paths |
| scan_out | output | 1 | Serial output of the last cell |
| scan_en | output | 1 | Scan enable applied to the cells |
| done | output | 1 | One-cycle end-of-test pulse |
| mismatch | output | 1 | Sticky result flag of the last test |

## Verification
The checks assume the tester drives `dm_sel` correctly. It raises `dm_sel` after a launch edge while `clk_fn` is high and `clk_ph` is still low. It keeps `dm_sel` high through shift-out. It drops `dm_sel` only while both clocks are low. The checks also assume that `vec_i`, `lbit_i`, `gold_i` and `care_i` stay steady during a test. The stimulus keeps to these rules by changing inputs only at falling edges of `clk_fn`. It raises and drops the select at fixed offsets inside those windows. The paths are modelled with two fixed delays that lie on either side of the phase offset, so each path is either fast or slow.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_SHIFT_IN,
    S_LAUNCH,
    S_CAPT,
    S_SHIFT_OUT,
    S_DONE
  } dcs_state_e;
endpackage

// File: rtl/dcs_clk_sel.sv
module dcs_clk_sel (
  input  logic clk_a,
  input  logic clk_b,
  input  logic sel_b,
  output logic clk_o
);
  // Glitch freedom is the tester's job: sel_b must change only where the
  // chosen clocks keep legal high and low widths.
  assign clk_o = sel_b ? clk_b : clk_a;
endmodule

// File: rtl/dcs_cell.sv
module dcs_cell (
  input  logic clk_fn,
  input  logic clk_ph,
  input  logic dm_sel,
  input  logic rst_n,
  input  logic sen,
  input  logic d,
  input  logic sd,
  output logic q
);
  logic clk_c;

  dcs_clk_sel u_csel (
    .clk_a (clk_fn),
    .clk_b (clk_ph),
    .sel_b (dm_sel),
    .clk_o (clk_c)
  );

  always_ff @(posedge clk_c or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= sen ? sd : d;
  end
endmodule

// File: rtl/dcs_ctrl.sv
module dcs_ctrl #(
  parameter int N = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [N-1:0]        vec_i,
  input  logic                lbit_i,
  input  logic [N-1:0]        gold_i,
  input  logic [N-1:0]        care_i,
  input  logic                so,
  output logic                sen,
  output logic                si,
  output logic                done,
  output logic                mismatch,
  output dcs_pkg::dcs_state_e st
);
  import dcs_pkg::*;

  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] idx;

  assign idx  = LAST - cnt;
  assign done = (st == S_DONE);

  always_comb begin
    sen = 1'b0;
    si  = 1'b0;
    case (st)
      S_SHIFT_IN:  begin sen = 1'b1; si = vec_i[idx]; end
      S_LAUNCH:    begin sen = 1'b1; si = lbit_i;     end
      S_SHIFT_OUT: begin sen = 1'b1; si = 1'b0;       end
      default:     begin sen = 1'b0; si = 1'b0;       end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      mismatch <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st       <= S_SHIFT_IN;
          cnt      <= '0;
          mismatch <= 1'b0;
        end
        S_SHIFT_IN: begin
          if (cnt == LAST) begin
            cnt <= '0;
            st  <= S_LAUNCH;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_LAUNCH: st <= S_CAPT;
        S_CAPT:   st <= S_SHIFT_OUT;
        S_SHIFT_OUT: begin
          mismatch <= mismatch | ((so ^ gold_i[idx]) & care_i[idx]);
          if (cnt == LAST) begin
            cnt <= '0;
            st  <= S_DONE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcs_chain.sv
module dcs_chain #(
  parameter int N = 8
) (
  input  logic         clk_fn,
  input  logic         clk_ph,
  input  logic         rst_n,
  input  logic         dm_sel,
  input  logic         start,
  input  logic [N-1:0] vec_i,
  input  logic         lbit_i,
  input  logic [N-1:0] gold_i,
  input  logic [N-1:0] care_i,
  input  logic [N-1:0] func_d,
  output logic [N-1:0] cell_q,
  output logic         scan_out,
  output logic         scan_en,
  output logic         done,
  output logic         mismatch
);
  import dcs_pkg::*;

  logic       clk_ctl;
  logic       si;
  dcs_state_e st;

  dcs_clk_sel u_ctl_csel (
    .clk_a (clk_fn),
    .clk_b (clk_ph),
    .sel_b (dm_sel),
    .clk_o (clk_ctl)
  );

  dcs_ctrl #(.N(N)) u_ctrl (
    .clk      (clk_ctl),
    .rst_n    (rst_n),
    .start    (start),
    .vec_i    (vec_i),
    .lbit_i   (lbit_i),
    .gold_i   (gold_i),
    .care_i   (care_i),
    .so       (scan_out),
    .sen      (scan_en),
    .si       (si),
    .done     (done),
    .mismatch (mismatch),
    .st       (st)
  );

  for (genvar i = 0; i < N; i++) begin : g_cell
    logic sd_w;
    if (i == 0) begin : g_head
      assign sd_w = si;
    end else begin : g_link
      assign sd_w = cell_q[i-1];
    end
    dcs_cell u_cell (
      .clk_fn (clk_fn),
      .clk_ph (clk_ph),
      .dm_sel (dm_sel),
      .rst_n  (rst_n),
      .sen    (scan_en),
      .d      (func_d[i]),
      .sd     (sd_w),
      .q      (cell_q[i])
    );
  end

  assign scan_out = cell_q[N-1];
endmodule

// File: rtl/dcs_chain_chk.sv
module dcs_chain_chk (
  input logic                clk_ctl,
  input logic                rst_n,
  input logic                start,
  input logic                dm_sel,
  input dcs_pkg::dcs_state_e st,
  input logic                scan_en,
  input logic                done,
  input logic                mismatch
);
  import dcs_pkg::*;

  p_capture_gap_r5: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    (st == S_LAUNCH) |=> (!scan_en ##1 scan_en));

  p_done_pulse_r8: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    done |=> !done);

  p_done_after_shift_r8: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    $rose(done) |-> ($past(st) == S_SHIFT_OUT));

  p_sticky_r8: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    (st == S_IDLE && !start) |=> $stable(mismatch));

  p_clear_on_start_r8: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    (st == S_IDLE && start) |=> !mismatch);

  p_dm_held_r3: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    (st == S_SHIFT_OUT) |-> dm_sel);

  p_start_ignored_r10: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    (st == S_SHIFT_IN && start) |=> (st == S_SHIFT_IN || st == S_LAUNCH));
endmodule

bind dcs_chain dcs_chain_chk u_chk (
  .clk_ctl  (clk_ctl),
  .rst_n    (rst_n),
  .start    (start),
  .dm_sel   (dm_sel),
  .st       (st),
  .scan_en  (scan_en),
  .done     (done),
  .mismatch (mismatch)
);

// File: tb/dcs_chain_tb.sv
`timescale 1ns/1ps
module dcs_chain_tb;
  localparam int N = 8;

  logic         clk_fn = 1'b0;
  logic         clk_ph;
  logic         rst_n, dm_sel, start, lbit_i;
  logic [N-1:0] vec_i, gold_i, care_i, slow_sel;
  logic [N-1:0] path_fast, path_slow, func_d;
  logic [N-1:0] cell_q;
  logic         scan_out, scan_en, done, mismatch;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk_fn = ~clk_fn;
  assign #5 clk_ph = clk_fn;

  function automatic logic [N-1:0] pathf(input logic [N-1:0] v);
    return ~{v[0], v[N-1:1]};
  endfunction

  function automatic logic [N-1:0] launch_vec(input logic [N-1:0] v, input logic b);
    return {v[N-2:0], b};
  endfunction

  function automatic logic [N-1:0] resp_of(input logic [N-1:0] v, input logic b,
                                           input logic [N-1:0] slow);
    return (pathf(v) & slow) | (pathf(launch_vec(v, b)) & ~slow);
  endfunction

  assign #3 path_fast = pathf(cell_q);
  assign #8 path_slow = pathf(cell_q);
  assign func_d = (path_fast & ~slow_sel) | (path_slow & slow_sel);

  dcs_chain #(.N(N)) u_dut (
    .clk_fn (clk_fn), .clk_ph (clk_ph), .rst_n (rst_n), .dm_sel (dm_sel),
    .start (start), .vec_i (vec_i), .lbit_i (lbit_i), .gold_i (gold_i),
    .care_i (care_i), .func_d (func_d), .cell_q (cell_q), .scan_out (scan_out),
    .scan_en (scan_en), .done (done), .mismatch (mismatch)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Called at a falling edge of clk_fn with the sequencer idle.
  task automatic run_test(input logic [N-1:0] v, input logic b, input logic [N-1:0] slow,
                          input logic [N-1:0] care, input logic [N-1:0] gold,
                          input bit mid_start);
    logic [N-1:0] r;
    logic exp_mm;
    r = resp_of(v, b, slow);
    exp_mm = |((r ^ gold) & care);
    vec_i = v; lbit_i = b; slow_sel = slow; care_i = care; gold_i = gold;
    start = 1'b1;
    @(posedge clk_fn);
    @(negedge clk_fn);
    start = mid_start;
    chk("R8 clear on start", mismatch, 0);
    chk("R5 sen in shift-in", scan_en, 1);
    @(posedge clk_fn);
    #5 start = 1'b0;
    repeat (N) @(posedge clk_fn);
    #2 dm_sel = 1'b1;
    #1;
    chk("R5 sen low in capture cycle", scan_en, 0);
    chk("R4 launch vector", cell_q, launch_vec(v, b));
    #7;
    chk("R3 captured response", cell_q, r);
    chk("R6 scan_out bit N-1", scan_out, r[N-1]);
    chk("R5 sen in shift-out", scan_en, 1);
    chk("R8 done low early", done, 0);
    for (int k = 2; k <= N; k++) begin
      #20;
      chk("R6 scan_out stream", scan_out, r[N-k]);
      if (k == N) chk("R8 done not yet", done, 0);
    end
    #20;
    chk("R8 done pulse", done, 1);
    chk("R7 R9 mismatch", mismatch, exp_mm);
    #7 dm_sel = 1'b0;
    #13;
    chk("R8 done one cycle", done, 0);
    chk("R8 mismatch held", mismatch, exp_mm);
    @(negedge clk_fn);
    chk("R8 mismatch still held", mismatch, exp_mm);
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] prev, v, sl, cr, gd;
    logic b;
    int unsigned seed;
    seed = $urandom(32'd20240611);
    rst_n = 1'b0; dm_sel = 1'b0; start = 1'b0; lbit_i = 1'b0;
    vec_i = '0; gold_i = '0; care_i = '0; slow_sel = '0;
    @(negedge clk_fn);
    @(negedge clk_fn);
    chk("R1 cells in reset", cell_q, 0);
    chk("R1 sen in reset", scan_en, 0);
    chk("R1 done in reset", done, 0);
    chk("R1 mismatch in reset", mismatch, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      prev = cell_q;
      @(negedge clk_fn);
      chk("R2 functional load", cell_q, pathf(prev));
      chk("R2 sen idle", scan_en, 0);
    end
    // Directed: all paths fast, golden right
    run_test(8'h55, 1'b1, 8'h00, 8'hFF, pathf(launch_vec(8'h55, 1'b1)), 0);
    // Directed: one slow path with a transition, watched
    run_test(8'h55, 1'b0, 8'h08, 8'hFF, pathf(launch_vec(8'h55, 1'b0)), 0);
    // Directed: same slow path, masked out
    run_test(8'h55, 1'b0, 8'h08, 8'hF7, pathf(launch_vec(8'h55, 1'b0)), 0);
    // Directed: slow path without a transition stays quiet
    run_test(8'h0F, 1'b1, 8'h02, 8'hFF, pathf(launch_vec(8'h0F, 1'b1)), 0);
    // Directed: start repeated while busy (R10)
    run_test(8'hA3, 1'b1, 8'h10, 8'hFF, pathf(launch_vec(8'hA3, 1'b1)), 1);
    // Directed: slow top path fed by the launch bit
    run_test(8'h01, 1'b0, 8'h80, 8'h80, pathf(launch_vec(8'h01, 1'b0)), 0);
    for (int t = 0; t < 24; t++) begin
      v  = N'($urandom);
      b  = 1'($urandom);
      sl = N'($urandom) & N'($urandom) & N'($urandom);
      cr = N'($urandom) | N'($urandom);
      gd = pathf(launch_vec(v, b));
      if (($urandom % 4) == 0) gd = gd ^ (N'(1) << ($urandom % N));
      run_test(v, b, sl, cr, gd, (($urandom % 5) == 0));
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule